// File: doc/BRIEF.md
# Bit-Banged Serial Memory Responder

This block stands in for a small serial memory that software drives one bit at a time through a single 32-bit control word. The host writes the control word to move a software clock bit and a data-in bit. On each write that takes the clock bit from 0 to 1, the block takes one step of a serial-memory transaction. It first assembles an 8-bit command and then, for a read, an 8-bit word address. After that it presents the addressed 16-bit word on a data-out bit, lowest bit first, one bit per clock step. A status command returns eight zero bits instead.

The stored words are fixed at reset. Word 0 holds 0xBABA and every other word holds zero. The host reads the control word back at any time to observe data-out and the grant bit. The grant bit follows the request bit on every accepted write. Commands other than the two supported ones, and addresses past the storage depth, produce a one-cycle error pulse. The sequencer then drops back to waiting for a new command.

Control-word bit map: bit 0 software clock, bit 1 data-in, bit 3 data-out (block-owned), bits 5:4 write-enable field, bit 6 request, bit 7 grant (block-owned), bit 13 memory-type flag. All other bits are plain storage.

Top module: `serial_prom_emul`

## Requirements
- R1: After reset the control word reads 0x00002010 (write-enable field = 01, type flag bit 13 = 1, all else 0) and err_flag is 0.
- R2: A write whose wr_strb is not 4'hF is ignored entirely: the control word does not change, and no serial step is taken.
- R3: After an accepted write, the control word reads back as the written value, with two exceptions. Bit 7 (grant) equals the written bit 6 (request). Bit 3 shows the block's data-out.
- R4: A serial step happens only on an accepted write that changes bit 0 from 0 to 1. Writes that keep bit 0 low, or keep it high, shift nothing and leave data-out unchanged.
- R5: The first 8 steps shift bit 1 into the command, most significant bit first. Command 0x03 selects read and 0x05 selects status.
- R6: For a read, the next 8 steps shift in the word address most significant bit first. The 16 steps after that each put bit k of the addressed word on bit 3, for k = 0 to 15 in order, readable right after the write.
- R7: For a status command, the 8 following steps each drive bit 3 to 0.
- R8: After the 16th data step of a read, or the 8th step of a status command, the block waits for a new 8-bit command.
- R9: Storage depth is 64 words of 16 bits. Word 0 reads 0xBABA and words 1 to 63 read 0.
- R10: A completed command other than 0x03 or 0x05 raises err_flag for exactly one cycle, in the cycle after the 8th step's write. The block then waits for a new command.
- R11: A read address of 64 or more raises the same one-cycle err_flag after the 8th address step, and the block then waits for a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write of the control word this cycle |
| wr_strb | input | 4 | Byte strobes; only 4'hF is a legal access |
| wr_data | input | 32 | Value written to the control word |
| rd_data | output | 32 | Current control word as seen by the host |
| err_flag | output | 1 | One-cycle pulse on an unknown command or out-of-range address |

## Verification
Every result of a write is due one clock after the edge that takes the write. This covers the read-back word, the grant bit, the data-out bit for a step and the error pulse. Each write is driven on a falling edge and held for one cycle, and its results are sampled on the next falling edge. The absence of a second error pulse is sampled one cycle later still. Ignored writes are judged by reading the whole control word back right after them, and by checking that the transaction in progress still produces the correct bit sequence afterwards.

// File: rtl/serial_prom_pkg.sv
`timescale 1ns/1ps
package serial_prom_pkg;
  localparam int CTRL_W   = 32;
  localparam int SK_POS   = 0;
  localparam int DIN_POS  = 1;
  localparam int DOUT_POS = 3;
  localparam int REQ_POS  = 6;
  localparam int GNT_POS  = 7;
  localparam int CMD_W    = 8;
  localparam int ADR_W    = 8;
  localparam int STAT_W   = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0000_2010;
  localparam logic [CTRL_W-1:0] OWNED_MASK = (32'h1 << DOUT_POS) | (32'h1 << GNT_POS);
  localparam logic [CMD_W-1:0]  CMD_READ   = 8'h03;
  localparam logic [CMD_W-1:0]  CMD_STATUS = 8'h05;

  typedef enum logic [1:0] {PH_CMD, PH_ADR, PH_DATA, PH_STAT} phase_e;
endpackage

// File: rtl/serial_prom_store.sv
`timescale 1ns/1ps
module serial_prom_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] WORD0 = 16'hBABA,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (i == 0) begin : g_first
      assign cells[i] = WORD0;
    end else begin : g_rest
      assign cells[i] = '0;
    end
  end

  assign rd_word = cells[rd_idx];
endmodule

// File: rtl/serial_prom_ctrl.sv
`timescale 1ns/1ps
module serial_prom_ctrl import serial_prom_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_strb,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              step_en,
  output logic              din_bit
);
  logic              wr_ok;
  logic [CTRL_W-1:0] ctrl_d;

  assign wr_ok   = wr_en & (&wr_strb);
  assign step_en = wr_ok & ~ctrl_q[SK_POS] & wr_data[SK_POS];
  assign din_bit = wr_data[DIN_POS];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) ctrl_d = wr_data & ~OWNED_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/serial_prom_seq.sv
`timescale 1ns/1ps
module serial_prom_seq import serial_prom_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              din_bit,
  input  logic [WORD_W-1:0] rd_word,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              dout,
  output logic              err_pulse
);
  phase_e             ph_q, ph_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [ADR_W-1:0]   adr_q, adr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               dout_q, dout_d;
  logic               err_q, err_d;

  always_comb begin
    ph_d   = ph_q;
    cmd_d  = cmd_q;
    adr_d  = adr_q;
    cnt_d  = cnt_q;
    dout_d = dout_q;
    err_d  = 1'b0;
    if (step_en) begin
      cnt_d = cnt_q + 1'b1;
      unique case (ph_q)
        PH_CMD: begin
          cmd_d = CMD_W'({cmd_q, din_bit});
          if (cnt_q == CNT_W'(CMD_W - 1)) begin
            cnt_d = '0;
            if (cmd_d == CMD_READ)        ph_d = PH_ADR;
            else if (cmd_d == CMD_STATUS) ph_d = PH_STAT;
            else begin
              err_d = 1'b1;
              cmd_d = '0;
            end
          end
        end
        PH_ADR: begin
          adr_d = ADR_W'({adr_q, din_bit});
          if (cnt_q == CNT_W'(ADR_W - 1)) begin
            cnt_d = '0;
            if ({1'b0, adr_d} >= (ADR_W + 1)'(DEPTH)) begin
              err_d = 1'b1;
              ph_d  = PH_CMD;
              cmd_d = '0;
              adr_d = '0;
            end else begin
              ph_d = PH_DATA;
            end
          end
        end
        PH_DATA: begin
          dout_d = rd_word[cnt_q];
          if (cnt_q == CNT_W'(WORD_W - 1)) begin
            ph_d  = PH_CMD;
            cmd_d = '0;
            adr_d = '0;
            cnt_d = '0;
          end
        end
        PH_STAT: begin
          dout_d = 1'b0;
          if (cnt_q == CNT_W'(STAT_W - 1)) begin
            ph_d  = PH_CMD;
            cmd_d = '0;
            cnt_d = '0;
          end
        end
        default: ph_d = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CMD;
      cmd_q  <= '0;
      adr_q  <= '0;
      cnt_q  <= '0;
      dout_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cmd_q  <= cmd_d;
      adr_q  <= adr_d;
      cnt_q  <= cnt_d;
      dout_q <= dout_d;
      err_q  <= err_d;
    end
  end

  assign rd_idx    = adr_q[IDX_W-1:0];
  assign dout      = dout_q;
  assign err_pulse = err_q;
endmodule

// File: rtl/serial_prom_emul.sv
`timescale 1ns/1ps
module serial_prom_emul import serial_prom_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_strb,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              err_flag
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic              step_en;
  logic              din_bit;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  serial_prom_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_strb (wr_strb),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .step_en (step_en),
    .din_bit (din_bit)
  );

  serial_prom_seq #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step_en   (step_en),
    .din_bit   (din_bit),
    .rd_word   (rd_word),
    .rd_idx    (rd_idx),
    .dout      (dout),
    .err_pulse (err_flag)
  );

  serial_prom_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  assign rd_data = ctrl_q
                 | (CTRL_W'(dout) << DOUT_POS)
                 | (CTRL_W'(ctrl_q[REQ_POS]) << GNT_POS);
endmodule

// File: rtl/serial_prom_chk.sv
`timescale 1ns/1ps
module serial_prom_chk import serial_prom_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [3:0]        wr_strb,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CTRL_W-1:0] rd_data,
  input logic              err_flag
);
  logic full_wr;
  logic rising;
  assign full_wr = wr_en & (&wr_strb);
  assign rising  = full_wr & ~rd_data[SK_POS] & wr_data[SK_POS];

  assert_grant_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr |=> rd_data[GNT_POS] == $past(wr_data[REQ_POS]));

  assert_partial_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&wr_strb)) |=> $stable(rd_data));

  assert_no_rise_no_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && !rising) |=> (rd_data[DOUT_POS] == $past(rd_data[DOUT_POS])) && !err_flag);

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> !err_flag);

  assert_err_after_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> $past(rising));
endmodule

bind serial_prom_emul serial_prom_chk u_chk (.*);

// File: tb/tb_serial_prom_emul.sv
`timescale 1ns/1ps
module tb_serial_prom_emul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_strb;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        err_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [31:0] BASE = 32'h0000_2010;

  always #10 clk = ~clk;

  serial_prom_emul dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_data(rd_data), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic wr(input logic [31:0] v, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0;
  endtask

  function automatic logic [15:0] word_of(input int a);
    return (a == 0) ? 16'hBABA : 16'h0000;
  endfunction

  // mode 0: plain low/high; mode 1: repeated low, partial high, repeated high
  task automatic step(input logic d, input int mode, output logic e);
    logic [31:0] lo, hi, prev;
    logic        d1;
    lo = BASE | (32'(d) << 1);
    hi = lo | 32'h1;
    if (mode == 0) begin
      wr(lo, 4'hF);
      wr(hi, 4'hF);
      e = err_flag;
    end else begin
      wr(lo, 4'hF);
      wr(lo, 4'hF);
      prev = rd_data;
      wr(hi, 4'h7);
      chk("R2 partial write ignored", rd_data, prev);
      wr(hi, 4'hF);
      e  = err_flag;
      d1 = rd_data[3];
      wr(hi, 4'hF);
      chk("R4 held-high write no shift", {31'b0, rd_data[3]}, {31'b0, d1});
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int mode, output logic e);
    for (int i = 7; i >= 0; i--) step(b[i], mode, e);
  endtask

  task automatic read_body(input int a, input int mode);
    logic e;
    logic [15:0] w;
    w = word_of(a);
    send_byte(8'(a), mode, e);
    chk("R6 address accepted", {31'b0, e}, 32'h0);
    for (int k = 0; k < 16; k++) begin
      step(1'b0, mode, e);
      chk($sformatf("R6 R9 addr %0d bit %0d", a, k), {31'b0, rd_data[3]}, {31'b0, w[k]});
    end
  endtask

  task automatic read_word(input int a, input int mode);
    logic e;
    send_byte(8'h03, mode, e);
    chk("R5 read command accepted", {31'b0, e}, 32'h0);
    read_body(a, mode);
  endtask

  task automatic status_body();
    logic e;
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 0, e);
      chk($sformatf("R7 status bit %0d", k), {31'b0, rd_data[3]}, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic e;
    rst_n = 1'b0; wr_en = 1'b0; wr_strb = 4'h0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset control word", rd_data, 32'h0000_2010);
    chk("R1 reset err_flag", {31'b0, err_flag}, 32'h0);

    wr(32'hA5A0_0C44, 4'hF);
    chk("R3 readback with grant", rd_data, 32'hA5A0_0CC4);
    wr(BASE, 4'hF);
    chk("R3 readback grant cleared", rd_data, BASE);
    wr(32'hFFFF_FFFF, 4'h3);
    chk("R2 partial write ignored", rd_data, BASE);

    for (int a = 0; a < 64; a++) read_word(a, 0);

    read_word(0, 1);

    read_word(0, 0);
    chk("R6 last bit of word 0 high", {31'b0, rd_data[3]}, 32'h1);
    send_byte(8'h05, 0, e);
    chk("R5 status command accepted", {31'b0, e}, 32'h0);
    status_body();
    read_word(0, 0);
    chk("R8 command after status", {31'b0, rd_data[3]}, 32'h1);

    for (int op = 0; op < 256; op++) begin
      send_byte(8'(op), 0, e);
      if (op == 3) begin
        chk("R5 opcode 03", {31'b0, e}, 32'h0);
        read_body(op % 64, 0);
      end else if (op == 5) begin
        chk("R5 opcode 05", {31'b0, e}, 32'h0);
        status_body();
      end else begin
        chk($sformatf("R10 bad opcode %0h error", op), {31'b0, e}, 32'h1);
        @(negedge clk);
        chk("R10 error lasts one cycle", {31'b0, err_flag}, 32'h0);
      end
    end

    for (int j = 0; j < 4; j++) begin
      int a;
      a = (j == 0) ? 64 : (j == 1) ? 65 : (j == 2) ? 128 : 255;
      send_byte(8'h03, 0, e);
      send_byte(8'(a), 0, e);
      chk($sformatf("R11 address %0d error", a), {31'b0, e}, 32'h1);
      @(negedge clk);
      chk("R11 error lasts one cycle", {31'b0, err_flag}, 32'h0);
      read_word(0, 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule